// File: doc/BRIEF.md
# Slow-Domain Register Write Bridge

This block lets a fast bus clock (tens of MHz) commit writes into a small set of registers that live on a slow clock (tens of kHz). A write captured on the bus side is held there. A toggle request carries it across to the slow side, where it is applied. A toggle acknowledge returns to the bus side and ends the write.

Five targets are served. Address 0 is a control word, address 1 is a whole-second alarm and address 2 is a fractional-second alarm; these three load a register in the slow domain. Address 3 clears the seconds interrupt and address 4 clears the fractional interrupt; these two produce a single-cycle pulse in the slow domain. Each target has its own in-flight flag. Software polls a status word that holds these flags, their OR and a sticky error bit. The error bit flags a write that arrived while its target was still in flight.

Top module: `slow_reg_bridge`

## Requirements
- R1: After reset the status word is zero, all three slow-side registers read zero and neither clear pulse is asserted.
- R2: A write to an idle target at address 0 to 4 sets status bit N (N = address) and status bit 5 (any-busy) at the first bus clock edge that samples the write.
- R3: Once a write to address 0, 1 or 2 is no longer busy, the matching slow-side output (ctrl_q, alarm_sec_q, alarm_sub_q) holds the written data. These outputs change only when such a write is applied.
- R4: A busy bit clears no later than three slow clock periods plus three bus clock cycles after its write, and the aggregate bit 5 clears when all five bits are clear.
- R5: A write to a target whose busy bit is set is dropped and leaves that target's value unchanged. It sets the sticky error bit, status bit 6.
- R6: Each accepted write to address 3 raises clr_sec_pulse, and each accepted write to address 4 raises clr_sub_pulse. The pulse lasts exactly one slow clock cycle and is raised once per write. Neither write changes a loaded register.
- R7: A write to address 7 clears the error bit, unless an error is being set in the same cycle.
- R8: Writes to addresses 5 and 6 have no effect on the status word or the slow-side outputs.
- R9: Different targets are independent: writes to two idle targets on consecutive bus cycles are both accepted and both applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst_n | input | 1 | Bus-side asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | 3 | Target address |
| wr_data | input | DW | Write data |
| status | output | 7 | [4:0] busy per target, [5] any busy, [6] sticky error |
| slow_clk | input | 1 | Slow register clock |
| slow_rst_n | input | 1 | Slow-side asynchronous reset, active low |
| ctrl_q | output | DW | Control register, slow domain |
| alarm_sec_q | output | DW | Whole-second alarm register, slow domain |
| alarm_sub_q | output | DW | Fractional-second alarm register, slow domain |
| clr_sec_pulse | output | 1 | Seconds interrupt clear pulse, slow domain |
| clr_sub_pulse | output | 1 | Fractional interrupt clear pulse, slow domain |

## Verification
A request toggle that falls out of step with its acknowledge shows up in the status word. The busy bit either never clears, which breaks the R4 bound within about fifty bus cycles, or it clears before the slow register has loaded, so the register read at that moment holds stale data. A corrupted held word or a missed collision shows as a wrong slow-side value, or a wrong error bit, at the first idle point after the write. Extra or missing clear pulses show in the per-target pulse counts, which are compared after every clear write.

// File: rtl/slow_reg_bridge.sv
module slow_reg_bridge #(
  parameter int DW = 32
) (
  input  logic          bus_clk,
  input  logic          bus_rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [6:0]    status,
  input  logic          slow_clk,
  input  logic          slow_rst_n,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] alarm_sec_q,
  output logic [DW-1:0] alarm_sub_q,
  output logic          clr_sec_pulse,
  output logic          clr_sub_pulse
);
  localparam int NREG  = 5;
  localparam int NLOAD = 3;
  localparam logic [2:0] ERR_CLR_ADDR = 3'd7;

  logic [NREG-1:0] hit, take, busy, req_t, ack_f1, ack_f2;
  logic [NREG-1:0] req_s1, req_s2, req_s3, apply;
  logic [DW-1:0]   hold  [NLOAD];
  logic [DW-1:0]   loadq [NLOAD];
  logic [1:0]      pulse_q;
  logic            err;

  genvar i;
  generate
    for (i = 0; i < NREG; i++) begin : g_hit
      assign hit[i] = wr_en && (wr_addr == 3'(i));
    end
  endgenerate

  assign busy  = req_t ^ ack_f2;
  assign take  = hit & ~busy;
  assign apply = req_s2 ^ req_s3;

  always_ff @(posedge bus_clk or negedge bus_rst_n) begin
    if (!bus_rst_n) begin
      req_t  <= '0;
      ack_f1 <= '0;
      ack_f2 <= '0;
      err    <= 1'b0;
    end else begin
      req_t  <= req_t ^ take;
      ack_f1 <= req_s3;
      ack_f2 <= ack_f1;
      if (|(hit & busy))
        err <= 1'b1;
      else if (wr_en && wr_addr == ERR_CLR_ADDR)
        err <= 1'b0;
    end
  end

  always_ff @(posedge slow_clk or negedge slow_rst_n) begin
    if (!slow_rst_n) begin
      req_s1  <= '0;
      req_s2  <= '0;
      req_s3  <= '0;
      pulse_q <= '0;
    end else begin
      req_s1  <= req_t;
      req_s2  <= req_s1;
      req_s3  <= req_s2;
      pulse_q <= apply[4:3];
    end
  end

  generate
    for (i = 0; i < NLOAD; i++) begin : g_load
      always_ff @(posedge bus_clk or negedge bus_rst_n) begin
        if (!bus_rst_n)   hold[i] <= '0;
        else if (take[i]) hold[i] <= wr_data;
      end

      always_ff @(posedge slow_clk or negedge slow_rst_n) begin
        if (!slow_rst_n)   loadq[i] <= '0;
        else if (apply[i]) loadq[i] <= hold[i];
      end

      p_hold_stable_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        busy[i] && $past(busy[i]) |-> $stable(hold[i]));

      p_load_on_apply_r3: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        !$stable(loadq[i]) |-> $past(apply[i]));
    end

    for (i = 0; i < NREG; i++) begin : g_chk
      p_busy_rise_r2: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        $rose(busy[i]) |-> $past(hit[i]));
    end

    for (i = 0; i < 2; i++) begin : g_pulse
      p_pulse_single_r6: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        pulse_q[i] |=> !pulse_q[i]);

      p_pulse_cause_r6: assert property (@(posedge slow_clk) disable iff (!slow_rst_n)
        pulse_q[i] |-> $past(apply[3+i]));
    end
  endgenerate

  p_err_set_r5: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    $rose(err) |-> $past(|(hit & busy)));

  assign status        = {err, |busy, busy};
  assign ctrl_q        = loadq[0];
  assign alarm_sec_q   = loadq[1];
  assign alarm_sub_q   = loadq[2];
  assign clr_sec_pulse = pulse_q[0];
  assign clr_sub_pulse = pulse_q[1];
endmodule

// File: tb/slow_reg_bridge_bench.sv
module slow_reg_bridge_bench;
  localparam int DW = 32;
  localparam int BUSY_MAX = 60;

  logic          bus_clk = 1'b0, slow_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [6:0]    status;
  logic [DW-1:0] ctrl_q, alarm_sec_q, alarm_sub_q;
  logic          clr_sec_pulse, clr_sub_pulse;

  int checks = 0, fails = 0;
  int pulse_cnt [2];
  int exp_pulse [2];
  logic [DW-1:0] model [3];
  logic err_exp = 1'b0;

  always #10  bus_clk  = ~bus_clk;
  always #165 slow_clk = ~slow_clk;

  slow_reg_bridge #(.DW(DW)) u_slow_reg_bridge (
    .bus_clk(bus_clk), .bus_rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .status(status), .slow_clk(slow_clk), .slow_rst_n(rst_n),
    .ctrl_q(ctrl_q), .alarm_sec_q(alarm_sec_q), .alarm_sub_q(alarm_sub_q),
    .clr_sec_pulse(clr_sec_pulse), .clr_sub_pulse(clr_sub_pulse));

  initial begin pulse_cnt[0] = 0; pulse_cnt[1] = 0; end
  always @(negedge slow_clk) begin
    if (clr_sec_pulse) pulse_cnt[0] <= pulse_cnt[0] + 1;
    if (clr_sub_pulse) pulse_cnt[1] <= pulse_cnt[1] + 1;
  end

  function automatic logic [6:0] exp_status(logic [4:0] b, logic e);
    return {e, |b, b};
  endfunction

  function automatic logic [DW-1:0] load_out(int a);
    case (a)
      0:       return ctrl_q;
      1:       return alarm_sec_q;
      default: return alarm_sub_q;
    endcase
  endfunction

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [DW-1:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (status[5] && n < 500) begin
      @(negedge bus_clk);
      n++;
    end
    repeat (20) @(negedge bus_clk);
  endtask

  task automatic check_all(string tag);
    for (int k = 0; k < 3; k++) check({tag, " R3 load"}, load_out(k), model[k]);
    check({tag, " R6 sec pulses"}, pulse_cnt[0], exp_pulse[0]);
    check({tag, " R6 sub pulses"}, pulse_cnt[1], exp_pulse[1]);
    check({tag, " R5 status"}, 32'(status), 32'(exp_status(5'b0, err_exp)));
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd4242));
    for (int k = 0; k < 3; k++) model[k] = '0;
    exp_pulse[0] = 0; exp_pulse[1] = 0;
    repeat (4) @(negedge slow_clk);
    @(negedge bus_clk);
    check("R1 status", 32'(status), 32'd0);
    for (int k = 0; k < 3; k++) check("R1 load", load_out(k), '0);
    check("R1 pulses", {clr_sec_pulse, clr_sub_pulse}, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge bus_clk);

    // R8: unused addresses
    wr(3'd5, 32'hDEAD_0005);
    check("R8 status a5", 32'(status), 32'd0);
    wr(3'd6, 32'hDEAD_0006);
    check("R8 status a6", 32'(status), 32'd0);
    repeat (100) @(negedge bus_clk);
    check_all("R8 after");

    // R9: two targets back to back
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h1111_0000;
    @(negedge bus_clk);
    wr_addr = 3'd1; wr_data = 32'h2222_0001;
    check("R9 first busy", 32'(status), 32'(exp_status(5'b00001, 1'b0)));
    @(negedge bus_clk);
    wr_en = 1'b0;
    check("R9 both busy", 32'(status), 32'(exp_status(5'b00011, 1'b0)));
    model[0] = 32'h1111_0000; model[1] = 32'h2222_0001;
    wait_idle(n);
    check("R9 R4 idle time", n <= BUSY_MAX, 1);
    check_all("R9");

    // R5 + R7 directed: collision, then clear
    wr(3'd2, 32'hAAAA_5555);
    wr(3'd2, 32'h0BAD_0BAD);
    err_exp = 1'b1;
    check("R5 err set", 32'(status), 32'(exp_status(5'b00100, 1'b1)));
    model[2] = 32'hAAAA_5555;
    wait_idle(n);
    check_all("R5 collide");
    wr(3'd7, '0);
    err_exp = 1'b0;
    check("R7 err clear", 32'(status), 32'd0);

    // random phase
    for (int it = 0; it < 60; it++) begin
      int a;
      logic [DW-1:0] d, d2;
      bit coll;
      a = $urandom_range(0, 4);
      d = $urandom; d2 = $urandom;
      coll = ($urandom_range(0, 2) == 0);
      wr(3'(a), d);
      check("R2 busy set", 32'(status), 32'(exp_status(5'(1 << a), err_exp)));
      if (coll) begin
        wr(3'(a), d2);
        err_exp = 1'b1;
        check("R5 ignored write", 32'(status), 32'(exp_status(5'(1 << a), 1'b1)));
      end
      if (a < 3) model[a] = d;
      else exp_pulse[a-3]++;
      wait_idle(n);
      check("R4 busy clear time", n <= BUSY_MAX, 1);
      check_all("rand");
      if ($urandom_range(0, 3) == 0) begin
        wr(3'd7, '0);
        err_exp = 1'b0;
        check("R7 err clear", 32'(status), 32'(exp_status(5'b0, 1'b0)));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule